// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Unit

This block holds four 16-bit up-counters. Each one has a start value and a control word of its own. A channel advances on prescaled system clocks, with a choice of four division ratios. In chained mode it instead advances once for each overflow of the channel one number below it. An increment past the all-ones count loads the start value rather than leaving zero. When enabled, the overflow also sends a one-cycle pulse on that channel's interrupt line. Channel n is meant to feed system interrupt number n+8.

Software uses a small register port. A two-bit channel select and a one-bit register select pick the target. A synchronous write strobe stores the start value or the control word. The read data shows either the live count or the control word of the selected channel, with no added latency. Chained overflows ripple through all four channels inside one clock. One system tick can therefore advance several channels at once.

Top module: `cascade_timer_unit`

## Requirements
- R1: After reset every count, start value and control word reads as zero, and every interrupt output is low.
- R2: In free-running mode, control bits 1:0 set the number of system clocks per increment: value 0 gives 1, 1 gives 64, 2 gives 256, 3 gives 1024.
- R3: Control bit 7 enables the channel, bit 6 enables its interrupt and bit 2 selects chained mode. The whole 16-bit control word reads back as written.
- R4: An increment applied to a count of 0xFFFF is an overflow. At that clock edge the count takes the start value instead of zero.
- R5: An overflow with control bit 6 set gives a one-cycle high pulse on irq[n] in the cycle after the overflow edge. Without bit 6 the line stays low.
- R6: A chained channel ignores the prescaler and advances once for each overflow of channel n-1 in the same clock. Overflows of chained channels continue to the channel above within that clock.
- R7: Channel 0 in chained mode never advances. An overflow of channel 3 affects no other channel.
- R8: A channel with bit 7 clear holds its count and never overflows or pulses, even when its lower neighbour overflows.
- R9: A control write that sets bit 7 on a disabled channel loads the count with the start value and restarts the prescaler from zero.
- R10: Writing the start value while a channel runs leaves the live count alone and takes effect at the next overflow.
- R11: With wr_en high, reg_sel 0 writes the start value and reg_sel 1 writes the control word of channel ch_sel at the clock edge. rd_data shows the count (reg_sel 0) or the control word (reg_sel 1) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected register |
| ch_sel | input | 2 | Channel select |
| reg_sel | input | 1 | 0: start value (write) / live count (read); 1: control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| irq | output | 4 | Per-channel interrupt pulses |

## Verification
The counting function runs under each of the four division ratios with start values near the wrap point. This separates the increment spacing from the reload value and shows the interrupt pulse timing. A chain of channel 0 at full rate with three chained channels above it checks that the ripple happens within one clock. Gaps in that chain check that it stops at a disabled channel. Other patterns cover a chained channel 0, a start-value rewrite during counting, and a control rewrite that keeps bit 7 set. These separate the enable-edge load from later writes.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
   // Control word field positions (software-visible encoding)
   localparam int CTL_PS_LSB = 0;
   localparam int CTL_PS_W   = 2;
   localparam int CTL_CHAIN  = 2;
   localparam int CTL_IRQ_EN = 6;
   localparam int CTL_RUN    = 7;

   typedef enum logic {
      REG_START_COUNT = 1'b0,
      REG_CONTROL     = 1'b1
   } ctu_reg_e;

   typedef struct packed {
      logic                run;
      logic                irq_en;
      logic                chain;
      logic [CTL_PS_W-1:0] ps;
   } ctu_mode_t;

   function automatic ctu_mode_t ctu_decode(input logic [15:0] w);
      ctu_mode_t m;
      m.run    = w[CTL_RUN];
      m.irq_en = w[CTL_IRQ_EN];
      m.chain  = w[CTL_CHAIN];
      m.ps     = w[CTL_PS_LSB +: CTL_PS_W];
      return m;
   endfunction
endpackage

// File: rtl/ctu_prescaler.sv
module ctu_prescaler #(
   parameter int DIV1_LOG2 = 6,
   parameter int DIV2_LOG2 = 8,
   parameter int DIV3_LOG2 = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       clr,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam int ACC_W = DIV3_LOG2;
   localparam logic [ACC_W-1:0] LIM1 = ACC_W'((32'd1 << DIV1_LOG2) - 32'd1);
   localparam logic [ACC_W-1:0] LIM2 = ACC_W'((32'd1 << DIV2_LOG2) - 32'd1);
   localparam logic [ACC_W-1:0] LIM3 = ACC_W'((32'd1 << DIV3_LOG2) - 32'd1);

   if (DIV1_LOG2 < 1 || DIV2_LOG2 <= DIV1_LOG2 || DIV3_LOG2 <= DIV2_LOG2 || DIV3_LOG2 > 20) begin : g_bad_div
      $error("ctu_prescaler: division exponents must rise strictly and stay within 1..20");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] limit;

   always_comb begin
      unique case (sel)
         2'd0:    limit = '0;
         2'd1:    limit = LIM1;
         2'd2:    limit = LIM2;
         default: limit = LIM3;
      endcase
   end

   assign tick = run && (acc_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (run)    acc_q <= tick ? '0 : acc_q + 1'b1;
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel != 2'd0) |=> (!tick || sel == 2'd0)) // R2
      else $error("prescaler ticked on consecutive cycles with a divider above one");
endmodule

// File: rtl/ctu_channel.sv
module ctu_channel
   import ctu_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int DIV1_LOG2 = 6,
   parameter int DIV2_LOG2 = 8,
   parameter int DIV3_LOG2 = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_start,
   input  logic             wr_ctl,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             chain_in,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] ctl,
   output logic             ovf,
   output logic             irq
);
   if (CNT_W < 8) begin : g_bad_width
      $error("ctu_channel: control word needs at least 8 bits");
   end

   logic [CNT_W-1:0] ctl_q, start_q, cnt_q;
   logic             irq_q;
   ctu_mode_t        mode, mode_new;
   logic             en_rise, pre_tick, step;

   assign mode     = ctu_decode(16'(ctl_q));
   assign mode_new = ctu_decode(16'(wr_data));
   assign en_rise  = wr_ctl && mode_new.run && !mode.run;

   ctu_prescaler #(
      .DIV1_LOG2 (DIV1_LOG2),
      .DIV2_LOG2 (DIV2_LOG2),
      .DIV3_LOG2 (DIV3_LOG2)
   ) i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode.run && !mode.chain),
      .clr   (en_rise),
      .sel   (mode.ps),
      .tick  (pre_tick)
   );

   assign step = mode.run && (mode.chain ? chain_in : pre_tick);
   assign ovf  = step && (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         irq_q   <= 1'b0;
      end else begin
         if (en_rise)       cnt_q <= start_q;
         else if (ovf)      cnt_q <= start_q;
         else if (step)     cnt_q <= cnt_q + 1'b1;
         if (wr_ctl)        ctl_q <= wr_data;
         if (wr_start)      start_q <= wr_data;
         irq_q <= ovf && mode.irq_en;
      end
   end

   assign count = cnt_q;
   assign ctl   = ctl_q;
   assign irq   = irq_q;

   AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == $past(start_q))) // R4
      else $error("count did not take the start value after wrap");

   AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(ovf)) // R5
      else $error("interrupt pulse without overflow");

   AST_CHAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.run && mode.chain && !chain_in && !en_rise) |=> (cnt_q == $past(cnt_q))) // R6
      else $error("chained channel moved without a lower overflow");

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.run && !en_rise) |=> (cnt_q == $past(cnt_q))) // R8
      else $error("disabled channel count changed");

   AST_IDLE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.run |-> !ovf) // R8
      else $error("disabled channel overflowed");

   AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> (cnt_q == $past(start_q))) // R9
      else $error("enable edge did not load the start value");
endmodule

// File: rtl/cascade_timer_unit.sv
module cascade_timer_unit
   import ctu_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CH_SEL_W  = 2,
   parameter int CNT_W     = 16,
   parameter int DIV1_LOG2 = 6,
   parameter int DIV2_LOG2 = 8,
   parameter int DIV3_LOG2 = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CH_SEL_W-1:0] ch_sel,
   input  logic                reg_sel,
   input  logic [CNT_W-1:0]    wr_data,
   output logic [CNT_W-1:0]    rd_data,
   output logic [NUM_CH-1:0]   irq
);
   if (NUM_CH != (1 << CH_SEL_W)) begin : g_bad_sel
      $error("cascade_timer_unit: NUM_CH must equal 2**CH_SEL_W");
   end

   logic [CNT_W-1:0]  cnt_arr [NUM_CH];
   logic [CNT_W-1:0]  ctl_arr [NUM_CH];
   logic [NUM_CH-1:0] ovf_vec;
   logic [NUM_CH-1:0] chain_vec;
   logic [NUM_CH-1:0] wr_start_vec, wr_ctl_vec;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assign wr_start_vec[n] = wr_en && (ch_sel == CH_SEL_W'(n)) && (reg_sel == REG_START_COUNT);
      assign wr_ctl_vec[n]   = wr_en && (ch_sel == CH_SEL_W'(n)) && (reg_sel == REG_CONTROL);

      if (n == 0) begin : g_base
         assign chain_vec[n] = 1'b0;
      end else begin : g_link
         assign chain_vec[n] = ovf_vec[n-1];
      end

      ctu_channel #(
         .CNT_W     (CNT_W),
         .DIV1_LOG2 (DIV1_LOG2),
         .DIV2_LOG2 (DIV2_LOG2),
         .DIV3_LOG2 (DIV3_LOG2)
      ) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_start (wr_start_vec[n]),
         .wr_ctl   (wr_ctl_vec[n]),
         .wr_data  (wr_data),
         .chain_in (chain_vec[n]),
         .count    (cnt_arr[n]),
         .ctl      (ctl_arr[n]),
         .ovf      (ovf_vec[n]),
         .irq      (irq[n])
      );
   end

   assign rd_data = (reg_sel == REG_CONTROL) ? ctl_arr[ch_sel] : cnt_arr[ch_sel];

   AST_BASE_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_arr[0][CTL_RUN] && ctl_arr[0][CTL_CHAIN] && !wr_ctl_vec[0]) |=> $stable(cnt_arr[0])) // R7
      else $error("channel 0 advanced in chained mode");
endmodule

// File: tb/test_cascade_timer_unit.sv
module test_cascade_timer_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  ch_sel = '0;
   logic        reg_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [3:0]  irq;

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   // reference state
   logic [15:0] m_cnt [4];
   logic [15:0] m_ctl [4];
   logic [15:0] m_rel [4];
   int          m_acc [4];
   logic [3:0]  m_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   cascade_timer_unit i_cascade_timer_unit (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .ch_sel (ch_sel),
      .reg_sel (reg_sel), .wr_data (wr_data), .rd_data (rd_data), .irq (irq)
   );

   function automatic int div_of(input logic [1:0] p);
      case (p)
         2'd0: return 1;
         2'd1: return 64;
         2'd2: return 256;
         default: return 1024;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit lo_ovf;
      bit tk;
      if (!rst_n) begin
         for (int n = 0; n < 4; n++) begin
            m_cnt[n] = '0; m_ctl[n] = '0; m_rel[n] = '0; m_acc[n] = 0;
         end
         m_irq = '0;
      end else begin
         lo_ovf = 1'b0;
         for (int n = 0; n < 4; n++) begin
            tk = 1'b0;
            if (m_ctl[n][7]) begin
               if (m_ctl[n][2]) tk = (n > 0) && lo_ovf;
               else if (m_acc[n] >= div_of(m_ctl[n][1:0]) - 1) begin
                  tk = 1'b1; m_acc[n] = 0;
               end else m_acc[n]++;
            end
            lo_ovf = tk && (m_cnt[n] == 16'hFFFF);
            if (lo_ovf) m_cnt[n] = m_rel[n];
            else if (tk) m_cnt[n] = m_cnt[n] + 16'd1;
            m_irq[n] = lo_ovf && m_ctl[n][6];
         end
         if (wr_en) begin
            if (reg_sel) begin
               if (wr_data[7] && !m_ctl[ch_sel][7]) begin
                  m_cnt[ch_sel] = m_rel[ch_sel]; m_acc[ch_sel] = 0;
               end
               m_ctl[ch_sel] = wr_data;
            end else m_rel[ch_sel] = wr_data;
         end
      end
   end

   task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      check("irq", {12'h0, irq}, {12'h0, m_irq});
      check(reg_sel ? "control" : "count", rd_data, reg_sel ? m_ctl[ch_sel] : m_cnt[ch_sel]);
   endtask

   int rot = 0;
   task automatic cyc(input logic we, input logic [1:0] ch, input logic rs, input logic [15:0] d);
      @(negedge clk);
      compare();
      wr_en = we; ch_sel = ch; reg_sel = rs; wr_data = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         rot = (rot + 1) % 8;
         cyc(1'b0, 2'(rot % 4), 1'(rot / 4), 16'h0);
      end
   endtask

   task automatic wr(input logic [1:0] ch, input logic rs, input logic [15:0] d);
      cyc(1'b1, ch, rs, d);
   endtask

   task automatic expect_cnt(input logic [1:0] ch, input logic [15:0] exp);
      cyc(1'b0, ch, 1'b0, 16'h0);
      @(negedge clk);
      check("direct count", rd_data, exp);
      compare();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state on every channel
      cur_req = "R1";
      idle(8);
      // R11: start value write does not show on count; control readback
      cur_req = "R11";
      wr(2'd0, 1'b0, 16'h1234);
      expect_cnt(2'd0, 16'h0000);
      // R3: full 16-bit control word stored, enable bit clear keeps it idle
      cur_req = "R3";
      wr(2'd2, 1'b1, 16'hF13C);
      idle(8);
      wr(2'd2, 1'b1, 16'h0000);
      // R9 / R4: channel 0 full rate from near wrap
      cur_req = "R9";
      wr(2'd0, 1'b0, 16'hFFF0);
      wr(2'd0, 1'b1, 16'h00C0);
      expect_cnt(2'd0, 16'hFFF1);
      cur_req = "R4";
      idle(40);
      // R10: rewrite start value while running
      cur_req = "R10";
      wr(2'd0, 1'b0, 16'hFFFA);
      idle(30);
      // R3: rewrite control keeping bit 7 set must not reload
      cur_req = "R3";
      wr(2'd0, 1'b1, 16'h0080);
      idle(20);
      wr(2'd0, 1'b1, 16'h0000);
      // R2 / R5: divided rates
      cur_req = "R2";
      wr(2'd1, 1'b0, 16'hFFFE);
      wr(2'd1, 1'b1, 16'h00C1);
      wr(2'd2, 1'b0, 16'hFFFF);
      wr(2'd2, 1'b1, 16'h00C2);
      wr(2'd3, 1'b0, 16'hFFFF);
      wr(2'd3, 1'b1, 16'h0083);
      idle(300);
      cur_req = "R5";
      idle(2500);
      // R8: disable all, counts frozen
      cur_req = "R8";
      for (int n = 1; n < 4; n++) wr(2'(n), 1'b1, 16'h0000);
      idle(50);
      // R6: full chain ripple
      cur_req = "R6";
      wr(2'd0, 1'b0, 16'hFFFF);
      wr(2'd1, 1'b0, 16'hFFFD);
      wr(2'd2, 1'b0, 16'hFFFF);
      wr(2'd3, 1'b0, 16'hFFFF);
      wr(2'd3, 1'b1, 16'h00C4);
      wr(2'd2, 1'b1, 16'h00C4);
      wr(2'd1, 1'b1, 16'h00C4);
      wr(2'd0, 1'b1, 16'h00C0);
      idle(60);
      // R8: break the chain at channel 2
      cur_req = "R8";
      wr(2'd2, 1'b1, 16'h0044);
      idle(40);
      // R7: channel 0 chained never moves; channel 3 overflow isolated
      cur_req = "R7";
      wr(2'd0, 1'b1, 16'h0000);
      wr(2'd0, 1'b1, 16'h00C4);
      idle(30);
      expect_cnt(2'd0, 16'hFFFF);
      wr(2'd3, 1'b1, 16'h0000);
      wr(2'd3, 1'b1, 16'h00C0);
      idle(20);
      // R11: reads of control through the port
      cur_req = "R11";
      idle(16);
      @(negedge clk);
      compare();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule